// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This block divides an unsigned 7-bit dividend by an unsigned 5-bit divisor over several clock cycles. A pulse on `start` while the block is idle captures both operands. A control state machine then steers a small datapath through three phases: it loads the working remainder, subtracts the whole divisor from it once per cycle while counting the subtractions, and publishes the result. The count of subtractions is the quotient. The value left over when the working remainder falls below the divisor is the remainder.

The time to finish depends on the data. An operation takes three clock edges plus one edge for each subtraction, so a large quotient means a long wait. The block shows its progress with a `busy` level and a one-cycle `done` pulse. A zero divisor is detected right after the operands are loaded and ends the operation early with an error flag. The published results stay unchanged until the next operation completes.

Top module: `repsub_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_err`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor b and dividend a, the published `quotient` equals floor(a/b) and `remainder` equals a mod b, so a = quotient*b + remainder with remainder < b. `div_err` reads 0.
- R3: When b is nonzero, `done` rises on the (q+3)-th rising clock edge, where q is the quotient and the edge that samples `start` counts as the first.
- R4: When the dividend is smaller than a nonzero divisor, the result is quotient 0 and remainder equal to the dividend, with `done` on the third edge.
- R5: `done` is high for exactly one cycle and is never high together with `busy`. `busy` is high from the edge after `start` is accepted until `done` rises, and both are low one cycle after `done`.
- R6: A zero divisor ends the operation with `done` on the second edge, `div_err` = 1, `quotient` all ones (127) and `remainder` equal to the low 5 bits of the dividend.
- R7: `start` is sampled only when the block is idle. A `start` pulse, with any operands, that arrives while `busy` or `done` is high does not change the result and does not begin a new operation.
- R8: `quotient`, `remainder` and `div_err` change only on the edge where `done` rises and hold their values in every other cycle. `div_err` returns to 0 after a later division by a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a division; honoured only when idle |
| dividend | input | 7 | Unsigned dividend, captured when start is accepted |
| divisor | input | 5 | Unsigned divisor, captured when start is accepted |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when results are published |
| quotient | output | 7 | Published quotient |
| remainder | output | 5 | Published remainder |
| div_err | output | 1 | Set when the last operation had a zero divisor |

## Verification
The bench mixes seeded random operand pairs with directed cases: divisor 1 with dividend 127, which gives the longest run and a full-range quotient; dividend equal to the divisor; dividend below the divisor; and zero divisors. An off-by-one in the compare would either make one subtraction too many, leaving the remainder wrapped around, or stop one early, leaving a remainder equal to the divisor. Either fault also shifts the measured latency. Stray `start` pulses are sent mid-run and in the `done` cycle. A block that sampled them would restart, change its results or raise `busy` again. After a zero-divisor run, a normal run follows to catch an error flag that sticks.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_control.sv
module div_control
  import div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic div_zero,
  input  logic can_sub,
  output logic ld_ops,
  output logic init_work,
  output logic sub_en,
  output logic publish,
  output logic zero_pub,
  output logic busy,
  output logic done
);
  div_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ld_ops    = 1'b0;
    init_work = 1'b0;
    sub_en    = 1'b0;
    publish   = 1'b0;
    zero_pub  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ld_ops  = 1'b1;
        state_d = ST_LOAD;
      end
      ST_LOAD: if (div_zero) begin
        zero_pub = 1'b1;
        state_d  = ST_DONE;
      end else begin
        init_work = 1'b1;
        state_d   = ST_ITER;
      end
      ST_ITER: if (can_sub) begin
        sub_en = 1'b1;
      end else begin
        publish = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign busy = (state_q == ST_LOAD) || (state_q == ST_ITER);
  assign done = (state_q == ST_DONE);

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_ops, init_work, sub_en, publish, zero_pub})); // R7
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ld_ops |-> (!busy && !done)); // R7
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int DVD_W = 7,
  parameter int DVS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_ops,
  input  logic             init_work,
  input  logic             sub_en,
  input  logic             publish,
  input  logic             zero_pub,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             div_zero,
  output logic             can_sub,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o,
  output logic             err_o
);
  localparam int PAD_W = DVD_W - DVS_W;

  logic [DVD_W-1:0] a_r, work_r, b_ext, diff, work_d;
  logic [DVS_W-1:0] b_r;
  logic [DVD_W-1:0] cnt_r;

  generate
    if (PAD_W > 0) begin : g_pad
      assign b_ext = {{PAD_W{1'b0}}, b_r};
    end else begin : g_nopad
      assign b_ext = b_r[DVD_W-1:0];
    end
  endgenerate

  assign div_zero = (b_r == '0);
  assign can_sub  = (work_r >= b_ext);
  assign diff     = work_r - b_ext;
  assign work_d   = init_work ? a_r : diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_r    <= '0;
      b_r    <= '0;
      work_r <= '0;
      cnt_r  <= '0;
      quo_o  <= '0;
      rem_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      if (ld_ops) begin
        a_r <= dividend;
        b_r <= divisor;
      end
      if (init_work || sub_en) work_r <= work_d;
      if (init_work)   cnt_r <= '0;
      else if (sub_en) cnt_r <= cnt_r + 1'b1;
      if (publish) begin
        quo_o <= cnt_r;
        rem_o <= work_r[DVS_W-1:0];
        err_o <= 1'b0;
      end else if (zero_pub) begin
        quo_o <= '1;
        rem_o <= a_r[DVS_W-1:0];
        err_o <= 1'b1;
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> !div_zero && (work_r >= b_ext)); // R2
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    publish |-> work_r < b_ext); // R2
endmodule

// File: rtl/repsub_divider.sv
module repsub_divider #(
  parameter int DVD_W = 7,
  parameter int DVS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder,
  output logic             div_err
);
  logic ld_ops, init_work, sub_en, publish, zero_pub, div_zero, can_sub;

  div_control u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .div_zero(div_zero), .can_sub(can_sub),
    .ld_ops(ld_ops), .init_work(init_work), .sub_en(sub_en),
    .publish(publish), .zero_pub(zero_pub),
    .busy(busy), .done(done)
  );

  div_datapath #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_dp (
    .clk(clk), .rst(rst),
    .ld_ops(ld_ops), .init_work(init_work), .sub_en(sub_en),
    .publish(publish), .zero_pub(zero_pub),
    .dividend(dividend), .divisor(divisor),
    .div_zero(div_zero), .can_sub(can_sub),
    .quo_o(quotient), .rem_o(remainder), .err_o(div_err)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_err))); // R8
  AST_ZERO_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (done && div_err) |-> (quotient == '1)); // R6
endmodule

// File: tb/tb_repsub_divider.sv
module tb_repsub_divider;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [6:0] dividend;
  logic [4:0] divisor;
  logic       busy, done, div_err;
  logic [6:0] quotient;
  logic [4:0] remainder;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  repsub_divider dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_err(div_err)
  );

  function automatic logic [6:0] exp_q(input logic [6:0] a, input logic [4:0] b);
    if (b == 0) return 7'h7f;
    return a / {2'b0, b};
  endfunction

  function automatic logic [4:0] exp_r(input logic [6:0] a, input logic [4:0] b);
    logic [6:0] m;
    if (b == 0) return a[4:0];
    m = a % {2'b0, b};
    return m[4:0];
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // stray: 0 none, 1 start pulse mid-run, 2 start pulse in done cycle
  task automatic run_op(input logic [6:0] a, input logic [4:0] b, input int stray);
    int edges = 0;
    int lat;
    logic [6:0] q;
    q = exp_q(a, b);
    lat = (b == 0) ? 2 : (int'(q) + 3);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(posedge clk); edges = 1;
    @(negedge clk);
    start = 1'b0;
    dividend = ~a; divisor = b + 5'd3;
    while (!done && edges < 400) begin
      if (busy !== 1'b1) chk("R5 busy during run", busy, 1);
      if (stray == 1 && edges == 2) start = 1'b1;
      @(posedge clk); edges++;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R3 latency", edges, lat);
    chk("R2 quotient", quotient, q);
    chk("R2 remainder", remainder, exp_r(a, b));
    chk("R6 err flag", div_err, (b == 0) ? 1 : 0);
    chk("R5 busy low at done", busy, 0);
    if (stray == 2) begin
      start = 1'b1; dividend = 7'd100; divisor = 5'd3;
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R5 done one cycle", done, 0);
    chk("R8 quotient held", quotient, q);
    chk("R8 remainder held", remainder, exp_r(a, b));
    @(posedge clk);
    @(negedge clk);
    chk("R7 idle after done", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 quotient", quotient, 0);
    chk("R1 remainder", remainder, 0);
    chk("R1 err", div_err, 0);
    rst = 1'b0;

    run_op(7'd127, 5'd1, 0);   // R2 R3 longest run
    run_op(7'd5, 5'd9, 0);     // R4 dividend below divisor
    run_op(7'd0, 5'd31, 0);    // R4 zero dividend
    run_op(7'd31, 5'd31, 0);   // R2 equal operands
    run_op(7'd100, 5'd0, 0);   // R6 zero divisor
    run_op(7'd45, 5'd7, 0);    // R8 err clears
    run_op(7'd90, 5'd4, 1);    // R7 stray start mid-run
    run_op(7'd63, 5'd0, 2);    // R6 R7 stray start in done cycle
    run_op(7'd77, 5'd10, 2);   // R7
    for (int i = 0; i < 60; i++) begin
      logic [6:0] ra;
      logic [4:0] rb;
      ra = 7'($urandom_range(0, 127));
      rb = 5'($urandom_range(0, 31));
      if (i % 15 == 0) rb = 5'd0;
      run_op(ra, rb, i % 3);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule